// File: doc/BRIEF.md
# AGC Resynchronization and Hold-Off Controller

This block decides when an automatic gain control stage restarts its measurement period. Software reaches it through a small register-write port. One address holds a control byte, one holds a 16-bit hold-off delay, and six more hold staged copies of the loop parameters: decimation ratio, averaging count, scale, initial signal gain, loop gain K and pole P. An external sync pin also feeds the block. Each rising edge on that pin starts a hold-off countdown that can be retriggered. When the countdown runs out, a sync is issued. A software sync command skips the delay and acts on the next clock.

Every sync pulses a one-cycle restart strobe to the averaging decimator. The current update sample is then emitted and counting starts toward the next one. If the initialise option is selected, the same sync also pulses a parameter-load strobe. That strobe clears the decimator and copies the staged parameters into the active set that drives the datapath. A lockout option accepts only the first pin event and ignores later ones until software clears it. The block also passes out a bypass select and an output-width code for the datapath.

Top module: `agc_sync_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `restart_o`, `param_load_o` and `bypass_o` are 0, `out_width_o` is 0, every active parameter output is 0, and no countdown is running.
- R2: Pin path timing. If `sync_pin_i` is first sampled high at rising edge n and the hold-off value is H (H nonzero), `restart_o` is high for exactly the one cycle that follows edge n+1+H. A pin held high for many cycles counts as one event.
- R3: A new rising edge on `sync_pin_i` while a countdown runs reloads the countdown with H. Only the restart from the last edge is produced.
- R4: While the hold-off value (address 1) is 0, neither a software sync nor a pin edge produces any restart or parameter load.
- R5: Software sync. A write to address 0 with bit 3 set (hold-off nonzero) makes `restart_o` high in the cycle after that write edge. It cancels any running countdown. Bit 3 is not stored, and every such write gives a new sync.
- R6: Initialise option, control bit 2. When the option is 1 at the sync, `param_load_o` pulses together with `restart_o`, and the active outputs take the staged values in that same cycle. When the option is 0, only `restart_o` pulses and the active outputs stay unchanged. A software sync uses bit 2 of the same write. A pin sync uses the stored bit at expiry.
- R7: Writes to addresses 2 to 7 stage the decimation ratio (12 bits), averaging count (8), scale (4), signal gain (12), loop gain K (8) and pole P (8), in that order, from the low bits of the write data. The active outputs do not change until a parameter load.
- R8: Lockout, control bit 1. While the bit is 1, only the first accepted pin edge after it was set starts a countdown, and later pin edges are ignored. Writing the bit to 0 clears the lockout. While the bit is 0, every pin edge is accepted.
- R9: Control bit 0 drives `bypass_o` and bits 7:5 drive `out_width_o`, both from the cycle after the write edge.
- R10: `param_load_o` is never high without `restart_o`. Each sync gives exactly one restart pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 16 | Register write data |
| sync_pin_i | input | 1 | External sync pin |
| restart_o | output | 1 | One-cycle decimator restart strobe |
| param_load_o | output | 1 | One-cycle decimator clear and parameter load strobe |
| bypass_o | output | 1 | Route data around the gain stage |
| out_width_o | output | 3 | Output truncation width code |
| dec_ratio_o | output | 12 | Active decimation ratio |
| avg_count_o | output | 8 | Active averaging count |
| scale_o | output | 4 | Active scale |
| sig_gain_o | output | 12 | Active initial signal gain |
| loop_k_o | output | 8 | Active loop gain K |
| pole_o | output | 8 | Active pole P |

## Verification
The bench builds the block with its default 16-bit hold-off counter and the default parameter widths. It uses short hold-off values (1 to 20), so that retriggers, cancellation by a software sync and lockout sequences all fit in a few cycles. One long value of 300 checks that a count using the upper counter byte still expires on the predicted edge. The staged writes include all-ones data, which shows that only the low bits of each field are kept.

// File: rtl/agc_sync_pkg.sv
package agc_sync_pkg;
    parameter int DATA_W = 16;
    parameter int ADDR_W = 3;
    parameter int NPARAM = 6;
    parameter int PW [NPARAM] = '{12, 8, 4, 12, 8, 8};

    function automatic int field_off(int idx);
        int s;
        s = 0;
        for (int k = 0; k < idx; k++) s += PW[k];
        return s;
    endfunction

    function automatic int field_max();
        int m;
        m = 0;
        for (int k = 0; k < NPARAM; k++) if (PW[k] > m) m = PW[k];
        return m;
    endfunction

    localparam int PTOT  = field_off(NPARAM);
    localparam int PWMAX = field_max();

    localparam logic [ADDR_W-1:0] ADR_CTRL  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADR_HOLD  = ADDR_W'(1);
    localparam int                ADR_PBASE = 2;

    localparam int BIT_BYP  = 0;
    localparam int BIT_IGN  = 1;
    localparam int BIT_INIT = 2;
    localparam int BIT_NOW  = 3;
    localparam int BIT_WLO  = 5;
endpackage

// File: rtl/agc_pin_edge.sv
module agc_pin_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o
);
    typedef struct packed {
        logic s1;
        logic s2;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = pin_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = st_q.s1 & ~st_q.s2;

    // A long high level on the pin yields a single event
    assert_single_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/agc_holdoff.sv
module agc_holdoff #(
    parameter int HOLD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              cancel_i,
    input  logic [HOLD_W-1:0] hold_i,
    output logic              busy_o,
    output logic              done_o
);
    localparam logic [HOLD_W-1:0] ONE = HOLD_W'(1);

    typedef struct packed {
        logic              run;
        logic [HOLD_W-1:0] cnt;
    } ho_st_t;

    ho_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cancel_i) begin
            st_d.run = 1'b0;
            st_d.cnt = '0;
        end else begin
            if (st_q.run) begin
                if (st_q.cnt == ONE) begin
                    st_d.run = 1'b0;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt - ONE;
                end
            end
            if (load_i) begin
                st_d.run = 1'b1;
                st_d.cnt = hold_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o = st_q.run;
    assign done_o = st_q.run && (st_q.cnt == ONE) && !cancel_i;

    // Countdown steps by one each cycle when left alone
    assert_countdown_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && !load_i && !cancel_i && st_q.cnt > ONE)
            |=> (st_q.run && st_q.cnt == $past(st_q.cnt) - ONE));

    // A zero delay is never loaded
    assert_no_zero_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> (hold_i != '0));
endmodule

// File: rtl/agc_shadow_regs.sv
module agc_shadow_regs
    import agc_sync_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en_i,
    input  logic [ADDR_W-1:0]       wr_addr_i,
    input  logic [PWMAX-1:0]        wr_data_i,
    input  logic                    load_i,
    output logic [PTOT-1:0]         act_o
);
    typedef struct packed {
        logic [PTOT-1:0] shd;
        logic [PTOT-1:0] act;
    } sh_st_t;

    sh_st_t          st_d, st_q;
    logic [PTOT-1:0] shd_next;

    for (genvar g = 0; g < NPARAM; g++) begin : g_field
        localparam int OFF = field_off(g);
        localparam int WID = PW[g];
        logic hit;
        assign hit = wr_en_i && (wr_addr_i == ADDR_W'(ADR_PBASE + g));
        assign shd_next[OFF +: WID] = hit ? wr_data_i[WID-1:0] : st_q.shd[OFF +: WID];
    end

    always_comb begin
        st_d     = st_q;
        st_d.shd = shd_next;
        if (load_i) st_d.act = st_q.shd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act_o = st_q.act;

    // Active set only moves on a parameter load
    assert_active_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> (act_o == $past(act_o)));
endmodule

// File: rtl/agc_sync_ctrl.sv
module agc_sync_ctrl
    import agc_sync_pkg::*;
#(
    parameter int HOLD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              sync_pin_i,
    output logic              restart_o,
    output logic              param_load_o,
    output logic              bypass_o,
    output logic [2:0]        out_width_o,
    output logic [PW[0]-1:0]  dec_ratio_o,
    output logic [PW[1]-1:0]  avg_count_o,
    output logic [PW[2]-1:0]  scale_o,
    output logic [PW[3]-1:0]  sig_gain_o,
    output logic [PW[4]-1:0]  loop_k_o,
    output logic [PW[5]-1:0]  pole_o
);
    typedef struct packed {
        logic              byp;
        logic              ign;
        logic              init;
        logic [2:0]        wsel;
        logic [HOLD_W-1:0] hold;
        logic              lock;
        logic              restart;
        logic              load;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    logic            pin_rise;
    logic            ho_busy, ho_done;
    logic            ctrl_wr, hold_wr;
    logic            sw_sync, pin_ok, fire, init_sel;
    logic [PTOT-1:0] act;

    agc_pin_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (sync_pin_i),
        .rise_o (pin_rise)
    );

    agc_holdoff #(.HOLD_W(HOLD_W)) u_holdoff (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (pin_ok),
        .cancel_i (sw_sync),
        .hold_i   (st_q.hold),
        .busy_o   (ho_busy),
        .done_o   (ho_done)
    );

    agc_shadow_regs u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i[PWMAX-1:0]),
        .load_i    (fire && init_sel),
        .act_o     (act)
    );

    always_comb begin
        st_d     = st_q;
        ctrl_wr  = wr_en_i && (wr_addr_i == ADR_CTRL);
        hold_wr  = wr_en_i && (wr_addr_i == ADR_HOLD);
        sw_sync  = ctrl_wr && wr_data_i[BIT_NOW] && (st_q.hold != '0);
        pin_ok   = pin_rise && (st_q.hold != '0) && !(st_q.ign && st_q.lock) && !sw_sync;
        fire     = sw_sync || ho_done;
        init_sel = sw_sync ? wr_data_i[BIT_INIT] : st_q.init;

        st_d.restart = fire;
        st_d.load    = fire && init_sel;
        st_d.lock    = st_q.ign ? (st_q.lock || pin_ok) : 1'b0;

        if (ctrl_wr) begin
            st_d.byp  = wr_data_i[BIT_BYP];
            st_d.ign  = wr_data_i[BIT_IGN];
            st_d.init = wr_data_i[BIT_INIT];
            st_d.wsel = wr_data_i[BIT_WLO +: 3];
        end
        if (hold_wr) st_d.hold = wr_data_i[HOLD_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign restart_o    = st_q.restart;
    assign param_load_o = st_q.load;
    assign bypass_o     = st_q.byp;
    assign out_width_o  = st_q.wsel;
    assign dec_ratio_o  = act[field_off(0) +: PW[0]];
    assign avg_count_o  = act[field_off(1) +: PW[1]];
    assign scale_o      = act[field_off(2) +: PW[2]];
    assign sig_gain_o   = act[field_off(3) +: PW[3]];
    assign loop_k_o     = act[field_off(4) +: PW[4]];
    assign pole_o       = act[field_off(5) +: PW[5]];

    // Load strobe always travels with a restart strobe
    assert_load_with_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        param_load_o |-> restart_o);

    // Zero delay with nothing pending: no sync follows
    assert_zero_hold_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.hold == '0 && !ho_busy) |=> !restart_o);

    // Engaged lockout keeps an idle counter idle
    assert_lockout_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ign && st_q.lock && !ho_busy) |=> !ho_busy);

    // Software sync lands on the next cycle
    assert_sw_sync_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == ADR_CTRL && wr_data_i[BIT_NOW] && st_q.hold != '0)
            |=> restart_o);
endmodule

// File: tb/agc_sync_ctrl_test.sv
module agc_sync_ctrl_test;
    import agc_sync_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic              rst_n;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic              sync_pin;
    logic              restart_o, param_load_o, bypass_o;
    logic [2:0]        out_width_o;
    logic [11:0]       dec_ratio_o, sig_gain_o;
    logic [7:0]        avg_count_o, loop_k_o, pole_o;
    logic [3:0]        scale_o;

    agc_sync_ctrl uut (
        .clk (clk), .rst_n (rst_n),
        .wr_en_i (wr_en), .wr_addr_i (wr_addr), .wr_data_i (wr_data),
        .sync_pin_i (sync_pin),
        .restart_o (restart_o), .param_load_o (param_load_o),
        .bypass_o (bypass_o), .out_width_o (out_width_o),
        .dec_ratio_o (dec_ratio_o), .avg_count_o (avg_count_o), .scale_o (scale_o),
        .sig_gain_o (sig_gain_o), .loop_k_o (loop_k_o), .pole_o (pole_o)
    );

    int    checks = 0, errors = 0;
    string phase  = "R1";
    bit    run_cmp = 0;
    int    n_rst = 0, n_load = 0, r0 = 0, l0 = 0;

    // Behavioural reference model
    int pw [6] = '{12, 8, 4, 12, 8, 8};
    bit m_p1, m_p2, m_run, m_lock, m_byp, m_ign, m_init, e_rst, e_load;
    int m_w, m_cnt, m_hold;
    int m_shd [6];
    int m_act [6];
    bit rise, sw, fire, ini, ok;

    task automatic check(string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_p1 = 0; m_p2 = 0; m_run = 0; m_lock = 0; m_byp = 0; m_ign = 0; m_init = 0;
            m_w = 0; m_cnt = 0; m_hold = 0; e_rst = 0; e_load = 0;
            for (int i = 0; i < 6; i++) begin m_shd[i] = 0; m_act[i] = 0; end
        end else begin
            rise = m_p1 && !m_p2;
            sw   = wr_en && wr_addr == 0 && wr_data[3] && m_hold != 0;
            fire = 0; ini = 0; ok = 0;
            if (sw) begin
                fire = 1; ini = wr_data[2]; m_run = 0; m_cnt = 0;
            end else begin
                ok = rise && m_hold != 0 && !(m_ign && m_lock);
                if (m_run) begin
                    if (m_cnt == 1) begin fire = 1; ini = m_init; m_run = 0; m_cnt = 0; end
                    else m_cnt--;
                end
                if (ok) begin m_run = 1; m_cnt = m_hold; end
            end
            m_lock = m_ign ? (m_lock || ok) : 0;
            if (fire && ini) for (int i = 0; i < 6; i++) m_act[i] = m_shd[i];
            e_rst = fire; e_load = fire && ini;
            if (wr_en && wr_addr == 0) begin
                m_byp = wr_data[0]; m_ign = wr_data[1]; m_init = wr_data[2]; m_w = int'(wr_data[7:5]);
            end
            if (wr_en && wr_addr == 1) m_hold = int'(wr_data);
            for (int i = 0; i < 6; i++)
                if (wr_en && wr_addr == ADDR_W'(2 + i)) m_shd[i] = int'(wr_data) & ((1 << pw[i]) - 1);
            m_p2 = m_p1; m_p1 = sync_pin;
        end
    end

    // Cycle compare against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && run_cmp) begin
            if (restart_o) n_rst++;
            if (param_load_o) n_load++;
            check({phase, " restart_o"}, restart_o, e_rst);
            check({phase, " param_load_o"}, param_load_o, e_load);
            check("R10 load without restart", param_load_o && !restart_o, 0);
            check("R9 bypass_o", bypass_o, m_byp);
            check("R9 out_width_o", out_width_o, m_w);
            check({phase, " dec_ratio_o"}, dec_ratio_o, m_act[0]);
            check({phase, " avg_count_o"}, avg_count_o, m_act[1]);
            check({phase, " scale_o"}, scale_o, m_act[2]);
            check({phase, " sig_gain_o"}, sig_gain_o, m_act[3]);
            check({phase, " loop_k_o"}, loop_k_o, m_act[4]);
            check({phase, " pole_o"}, pole_o, m_act[5]);
        end
    end

    task automatic wr(input int a, input int d);
        @(posedge clk); #2;
        wr_en = 1; wr_addr = ADDR_W'(a); wr_data = DATA_W'(d);
        @(posedge clk); #2;
        wr_en = 0;
    endtask

    task automatic pin_pulse(input int n);
        @(posedge clk); #2;
        sync_pin = 1;
        repeat (n) @(posedge clk);
        #2 sync_pin = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic mark();
        r0 = n_rst; l0 = n_load;
    endtask

    task automatic expect_syncs(string tag, int er, int el);
        @(negedge clk);
        check({tag, " restart count"}, n_rst - r0, er);
        check({tag, " load count"}, n_load - l0, el);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 0; wr_en = 0; wr_addr = '0; wr_data = '0; sync_pin = 0;
        idle(3); #2 rst_n = 1; run_cmp = 1;
        @(negedge clk);
        check("R1 reset restart_o", restart_o, 0);
        check("R1 reset param_load_o", param_load_o, 0);
        check("R1 reset bypass_o", bypass_o, 0);
        check("R1 reset dec_ratio_o", dec_ratio_o, 0);

        phase = "R9";
        wr(0, 16'h00A1);
        @(negedge clk);
        check("R9 bypass set", bypass_o, 1);
        check("R9 width code", out_width_o, 5);

        phase = "R7";
        wr(2, 16'hFFFF); wr(3, 16'h1234); wr(4, 16'hFFFF);
        wr(5, 16'h0ABC); wr(6, 16'h0077); wr(7, 16'h0055);
        idle(3); @(negedge clk);
        check("R7 staged not active", dec_ratio_o, 0);

        phase = "R4";
        wr(1, 0); mark();
        wr(0, 16'h000C); pin_pulse(2); idle(10);
        expect_syncs("R4", 0, 0);

        phase = "R2";
        wr(1, 3); wr(0, 0); mark();
        pin_pulse(8); idle(10);
        expect_syncs("R2", 1, 0);

        phase = "R6";
        wr(0, 16'h0004); mark();
        pin_pulse(1); idle(8);
        expect_syncs("R6", 1, 1);
        check("R6 dec ratio loaded", dec_ratio_o, 12'hFFF);
        check("R6 scale loaded", scale_o, 4'hF);
        check("R6 avg loaded", avg_count_o, 8'h34);

        phase = "R3";
        wr(1, 6); mark();
        pin_pulse(1); idle(3); pin_pulse(1); idle(15);
        expect_syncs("R3", 1, 1);

        phase = "R5";
        wr(0, 0); wr(1, 20); mark();
        pin_pulse(1); idle(3); wr(0, 16'h0008); idle(30);
        expect_syncs("R5 cancel", 1, 0);
        mark(); wr(0, 16'h0008); wr(0, 16'h0008); idle(3);
        expect_syncs("R5 repeat", 2, 0);
        wr(5, 16'h0123); mark(); wr(0, 16'h000C); idle(2);
        expect_syncs("R5 init", 1, 1);
        check("R6 gain from sw sync", sig_gain_o, 12'h123);

        phase = "R8";
        wr(1, 2); wr(0, 16'h0002); mark();
        pin_pulse(1); idle(5); pin_pulse(1); idle(5); pin_pulse(1); idle(5);
        expect_syncs("R8 locked", 1, 0);
        wr(0, 0); mark();
        pin_pulse(1); idle(5); pin_pulse(1); idle(5);
        expect_syncs("R8 open", 2, 0);
        wr(0, 16'h0002); mark();
        pin_pulse(1); idle(5); pin_pulse(1); idle(5);
        expect_syncs("R8 rearmed", 1, 0);

        phase = "R2";
        wr(0, 0); wr(1, 300); mark();
        pin_pulse(1); idle(290);
        expect_syncs("R2 long early", 0, 0);
        idle(20);
        expect_syncs("R2 long", 1, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule